// File: doc/BRIEF.md
# Delimited Record Slot Receiver

This block takes a continuous stream of bytes, several bytes per clock, in which records are packed back to back without any alignment. A record is a variable-length text field closed by a delimiter byte, followed by a fixed number of binary bytes. The block finds record boundaries on its own. It uses the delimiter to end the text part and a byte count to end the binary part. No framing signal from the bus is needed.

Finished records are placed into a ring of parallel record slots. One token marks the slot that receives the next record, so only one slot captures at a time. When a record completes, the token steps to the following slot, and the last slot hands it back to slot 0. Filled slots drain in ring order into a small output FIFO. The FIFO presents each record with a valid/ready handshake: the text bytes, their count, the binary bytes and a per-record truncation flag. All parsing runs at the input clock rate, and one bus word is taken every cycle while ready is high. The lane count must not exceed the fixed byte count plus one, so at most one record ends inside any bus word.

Top module: `rec_ring_rx`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, err_overflow is 0, and slot 0 holds the token.
- R2: Text bytes are stored in arrival order, byte i at out_name[8*i+7:8*i]. The delimiter (default 0x2C) is not stored. out_name_len gives the number of text bytes, and unused text bytes read as zero.
- R3: Exactly FIX_BYTES bytes follow the delimiter and make up the binary field. Binary byte j appears at out_fixed[8*j+7:8*j].
- R4: Within a word, lane 0 (in_data[7:0]) holds the earliest byte. A record may start on any lane. Bytes that follow the end of a record in the same word begin the next record in that same cycle.
- R5: If a non-delimiter byte arrives when NAME_MAX text bytes are already stored, the text field is forced closed and that byte becomes binary byte 0. The record's out_trunc is then 1 and its out_name_len is NAME_MAX. err_overflow is set and stays 1 until reset.
- R6: Records are captured in token order (slot 0, 1, ... SLOTS-1, 0, ...) and leave the output in the order they arrived.
- R7: When the slot that holds the token is still full, in_ready is 0. No record is lost or overwritten while the output is stalled.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and the record on the output does not change.
- R9: A byte equal to the delimiter inside the binary field is stored as data and does not end anything.
- R10: A delimiter as the first byte of a record gives a record with out_name_len 0.
- R11: Words presented with in_valid low have no effect on the parse state or on the records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | LANES*8 | Packed input bytes, lane 0 earliest |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_valid | output | 1 | A record is presented |
| out_ready | input | 1 | Consumer takes the presented record |
| out_name | output | NAME_MAX*8 | Text field bytes, byte 0 lowest |
| out_name_len | output | $clog2(NAME_MAX+1) | Number of text bytes |
| out_fixed | output | FIX_BYTES*8 | Binary field bytes, byte 0 lowest |
| out_trunc | output | 1 | Text field of this record was forced closed |
| err_overflow | output | 1 | Sticky: a forced text close has occurred |

## Verification
The checker watches the token on every cycle. The token must step by exactly one slot, with wrap, on each completed record and hold still otherwise. It also checks that no slot is loaded while full, that the output holds steady under backpressure, that the length limit and the truncation length are respected, that the error flag is sticky, and that the state is idle right after reset. Whether the bytes land in the right place cannot be seen from a property: field placement, handover across unaligned boundaries, delimiter bytes inside binary data, empty text fields, idle words and end-to-end ordering under a long output stall. These are shown only by the bench's scenarios, which compare every record leaving the block with a record built independently from the byte stream.

// File: rtl/rec_pkg.sv
package rec_pkg;

    typedef enum logic {
        PH_NAME = 1'b0,
        PH_FIX  = 1'b1
    } phase_e;

    function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
        return (idx + 1 == n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rec_parser.sv
module rec_parser
    import rec_pkg::*;
#(
    parameter int unsigned LANES     = 4,
    parameter int unsigned NAME_MAX  = 16,
    parameter int unsigned FIX_BYTES = 4,
    parameter logic [7:0]  DELIM     = 8'h2C,
    localparam int unsigned LEN_W    = $clog2(NAME_MAX + 1),
    localparam int unsigned FC_W     = $clog2(FIX_BYTES + 1),
    localparam int unsigned NW       = NAME_MAX * 8,
    localparam int unsigned FW       = FIX_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [LANES*8-1:0] word,
    output logic               done,
    output logic [NW-1:0]      done_name,
    output logic [LEN_W-1:0]   done_len,
    output logic [FW-1:0]      done_fix,
    output logic               done_trunc,
    output logic               err_sticky
);

    phase_e           ph_q, ph_n;
    logic [LEN_W-1:0] len_q, len_n;
    logic [FC_W-1:0]  fcnt_q, fcnt_n;
    logic [NW-1:0]    name_q, name_n;
    logic [FW-1:0]    fix_q, fix_n;
    logic             trunc_q, trunc_n;
    logic             err_q;
    logic             force_evt;

    always_comb begin
        ph_n       = ph_q;
        len_n      = len_q;
        fcnt_n     = fcnt_q;
        name_n     = name_q;
        fix_n      = fix_q;
        trunc_n    = trunc_q;
        force_evt  = 1'b0;
        done       = 1'b0;
        done_name  = '0;
        done_len   = '0;
        done_fix   = '0;
        done_trunc = 1'b0;
        for (int l = 0; l < int'(LANES); l++) begin
            logic [7:0] b;
            logic       to_fix;
            b      = word[l*8 +: 8];
            to_fix = 1'b0;
            if (ph_n == PH_NAME) begin
                if (b == DELIM) begin
                    ph_n = PH_FIX;
                end else if (int'(len_n) == int'(NAME_MAX)) begin
                    trunc_n   = 1'b1;
                    force_evt = 1'b1;
                    ph_n      = PH_FIX;
                    to_fix    = 1'b1;
                end else begin
                    name_n[int'(len_n)*8 +: 8] = b;
                    len_n = len_n + LEN_W'(1);
                end
            end else begin
                to_fix = 1'b1;
            end
            if (to_fix) begin
                fix_n[int'(fcnt_n)*8 +: 8] = b;
                fcnt_n = fcnt_n + FC_W'(1);
                if (int'(fcnt_n) == int'(FIX_BYTES)) begin
                    done       = 1'b1;
                    done_name  = name_n;
                    done_len   = len_n;
                    done_fix   = fix_n;
                    done_trunc = trunc_n;
                    ph_n       = PH_NAME;
                    len_n      = '0;
                    fcnt_n     = '0;
                    name_n     = '0;
                    fix_n      = '0;
                    trunc_n    = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_NAME;
            len_q   <= '0;
            fcnt_q  <= '0;
            name_q  <= '0;
            fix_q   <= '0;
            trunc_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (accept) begin
            ph_q    <= ph_n;
            len_q   <= len_n;
            fcnt_q  <= fcnt_n;
            name_q  <= name_n;
            fix_q   <= fix_n;
            trunc_q <= trunc_n;
            err_q   <= err_q | force_evt;
        end
    end

    assign err_sticky = err_q;

endmodule

// File: rtl/rec_slot.sv
module rec_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clear,
    input  logic [W-1:0] din,
    output logic         full,
    output logic [W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (clear) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/rec_fifo.sv
module rec_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (int'(cnt_q) == int'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (int'(wr_q) == int'(DEPTH) - 1) ? '0 : wr_q + AW'(1);
            if (do_pop)  rd_q <= (int'(rd_q) == int'(DEPTH) - 1) ? '0 : rd_q + AW'(1);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/rec_ring_rx.sv
module rec_ring_rx
    import rec_pkg::*;
#(
    parameter int unsigned LANES      = 4,
    parameter int unsigned NAME_MAX   = 16,
    parameter int unsigned FIX_BYTES  = 4,
    parameter int unsigned SLOTS      = 3,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter logic [7:0]  DELIM      = 8'h2C,
    localparam int unsigned LEN_W     = $clog2(NAME_MAX + 1),
    localparam int unsigned NW        = NAME_MAX * 8,
    localparam int unsigned FW        = FIX_BYTES * 8,
    localparam int unsigned REC_W     = NW + LEN_W + FW + 1,
    localparam int unsigned TOK_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [LANES*8-1:0] in_data,
    output logic               in_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [NW-1:0]      out_name,
    output logic [LEN_W-1:0]   out_name_len,
    output logic [FW-1:0]      out_fixed,
    output logic               out_trunc,
    output logic               err_overflow
);

    logic             accept;
    logic             rec_done;
    logic [NW-1:0]    p_name;
    logic [LEN_W-1:0] p_len;
    logic [FW-1:0]    p_fix;
    logic             p_trunc;
    logic [REC_W-1:0] rec_new;
    logic [TOK_W-1:0] token_q, drain_q;
    logic [SLOTS-1:0] slot_full, slot_load, slot_clear;
    logic [REC_W-1:0] slot_rec [SLOTS];
    logic             fifo_push, fifo_full, fifo_empty;
    logic [REC_W-1:0] fifo_dout;

    assign in_ready = !slot_full[token_q];
    assign accept   = in_valid && in_ready;

    rec_parser #(
        .LANES(LANES), .NAME_MAX(NAME_MAX), .FIX_BYTES(FIX_BYTES), .DELIM(DELIM)
    ) u_parse (
        .clk(clk), .rst(rst), .accept(accept), .word(in_data),
        .done(rec_done), .done_name(p_name), .done_len(p_len),
        .done_fix(p_fix), .done_trunc(p_trunc), .err_sticky(err_overflow)
    );

    assign rec_new = {p_trunc, p_fix, p_len, p_name};

    assign fifo_push = slot_full[drain_q] && !fifo_full;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_load[s]  = accept && rec_done && (int'(token_q) == s);
        assign slot_clear[s] = fifo_push && (int'(drain_q) == s);
        rec_slot #(.W(REC_W)) u_slot (
            .clk(clk), .rst(rst), .load(slot_load[s]), .clear(slot_clear[s]),
            .din(rec_new), .full(slot_full[s]), .dout(slot_rec[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            token_q <= '0;
            drain_q <= '0;
        end else begin
            if (accept && rec_done) token_q <= TOK_W'(ring_next(int'(token_q), SLOTS));
            if (fifo_push)          drain_q <= TOK_W'(ring_next(int'(drain_q), SLOTS));
        end
    end

    rec_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(fifo_push), .din(slot_rec[drain_q]),
        .full(fifo_full), .pop(out_ready), .dout(fifo_dout), .empty(fifo_empty)
    );

    assign out_valid = !fifo_empty;
    assign {out_trunc, out_fixed, out_name_len, out_name} = fifo_dout;

endmodule

// File: rtl/rec_ring_chk.sv
module rec_ring_chk #(
    parameter int unsigned SLOTS    = 3,
    parameter int unsigned TOK_W    = 2,
    parameter int unsigned REC_W    = 8,
    parameter int unsigned NAME_MAX = 16,
    parameter int unsigned LEN_W    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [REC_W-1:0] out_rec,
    input logic [LEN_W-1:0] out_len,
    input logic             out_trunc,
    input logic             err,
    input logic [TOK_W-1:0] token,
    input logic             rec_done,
    input logic [SLOTS-1:0] slot_full,
    input logic [SLOTS-1:0] slot_load
);

    logic step;
    assign step = in_valid && in_ready && rec_done;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready && !err && token == '0)); // R1

    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_len) <= int'(NAME_MAX))); // R2

    AST_TRUNC_LEN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_trunc) |-> (int'(out_len) == int'(NAME_MAX))); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R5

    AST_TOKEN_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (token == ((int'($past(token)) == int'(SLOTS) - 1) ? '0 : $past(token) + 1'b1))); // R6

    AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(token)); // R6

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (slot_load & slot_full) == '0); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rec))); // R8

endmodule

bind rec_ring_rx rec_ring_chk #(
    .SLOTS(SLOTS), .TOK_W(TOK_W), .REC_W(REC_W), .NAME_MAX(NAME_MAX), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_rec(fifo_dout),
    .out_len(out_name_len), .out_trunc(out_trunc), .err(err_overflow),
    .token(token_q), .rec_done(rec_done), .slot_full(slot_full), .slot_load(slot_load)
);

// File: tb/sim_rec_ring_rx.sv
module sim_rec_ring_rx;

    localparam int LANES = 4;
    localparam int NMAX  = 16;
    localparam int FIX   = 4;
    localparam int LEN_W = $clog2(NMAX + 1);
    localparam int MAXR  = 128;

    // vector table: {text length, seed}
    localparam int TAB [8][2] = '{'{5, 1}, '{0, 2}, '{16, 3}, '{3, 4},
                                  '{11, 5}, '{1, 6}, '{7, 7}, '{2, 8}};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [LANES*8-1:0] in_data = '0;
    logic               in_ready;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [NMAX*8-1:0]  out_name;
    logic [LEN_W-1:0]   out_name_len;
    logic [FIX*8-1:0]   out_fixed;
    logic               out_trunc;
    logic               err_overflow;

    always #10 clk = ~clk;

    rec_ring_rx u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_name(out_name),
        .out_name_len(out_name_len), .out_fixed(out_fixed), .out_trunc(out_trunc),
        .err_overflow(err_overflow)
    );

    int errors = 0;
    int checks = 0;

    logic [7:0]        strm [4096];
    int                nbytes = 0;
    int                pos = 0;
    logic [NMAX*8-1:0] e_name [MAXR];
    logic [LEN_W-1:0]  e_len  [MAXR];
    logic [FIX*8-1:0]  e_fix  [MAXR];
    logic              e_trunc[MAXR];
    int                nexp = 0;
    int                nrx = 0;
    int                cyc = 0;
    bit                saw_stall = 1'b0;
    bit                hold_pend = 1'b0;
    logic [NMAX*8+LEN_W+FIX*8:0] held;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic add_rec(input int nl, input int seed);
        logic [NMAX*8-1:0] nm;
        logic [FIX*8-1:0]  fx;
        nm = '0;
        for (int i = 0; i < nl; i++) begin
            nm[i*8 +: 8] = 8'h41 + 8'((seed + i) % 26);
            strm[nbytes++] = nm[i*8 +: 8];
        end
        strm[nbytes++] = 8'h2C;
        for (int j = 0; j < FIX; j++) begin
            // R9: odd seeds carry a delimiter value in binary byte 1
            fx[j*8 +: 8] = (j == 1 && seed % 2 == 1) ? 8'h2C : 8'(seed * 17 + j * 3);
            strm[nbytes++] = fx[j*8 +: 8];
        end
        e_name[nexp] = nm; e_len[nexp] = LEN_W'(nl); e_fix[nexp] = fx; e_trunc[nexp] = 1'b0;
        nexp++;
    endtask

    task automatic add_ovf(input int seed);
        logic [NMAX*8-1:0] nm;
        logic [FIX*8-1:0]  fx;
        for (int i = 0; i < NMAX + FIX; i++) begin
            logic [7:0] b;
            b = 8'h61 + 8'((seed + i) % 20);
            strm[nbytes++] = b;
            if (i < NMAX) nm[i*8 +: 8] = b;
            else          fx[(i-NMAX)*8 +: 8] = b;
        end
        e_name[nexp] = nm; e_len[nexp] = LEN_W'(NMAX); e_fix[nexp] = fx; e_trunc[nexp] = 1'b1;
        nexp++;
    endtask

    task automatic pad_stream(input int seed);
        add_rec((LANES - ((nbytes + 1 + FIX) % LANES)) % LANES, seed);
    endtask

    // driver: inputs change 1 time unit after the rising edge
    task automatic run_stream(input int stall);
        bit cur_v;
        bit cur_r;
        int wait_c;
        cur_v = 1'b0;
        cur_r = 1'b0;
        cyc = 0;
        while (pos < nbytes || cur_v) begin
            @(posedge clk);
            #1;
            if (cur_v && cur_r) pos += LANES;
            cyc++;
            out_ready = (cyc > stall) && (cyc % 4 != 3);
            if (pos < nbytes && (cyc % 5 != 2)) begin
                cur_v = 1'b1;
                for (int l = 0; l < LANES; l++) in_data[l*8 +: 8] = strm[pos + l];
            end else begin
                cur_v = 1'b0;
                in_data = {LANES{8'h2C}}; // R11: ignored idle word
            end
            in_valid = cur_v;
            cur_r = in_ready;
            if (!in_ready) saw_stall = 1'b1;
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        wait_c = 0;
        while (nrx < nexp && wait_c < 2000) begin
            @(posedge clk);
            wait_c++;
        end
        #1;
        chk(nrx == nexp, "R6 record count", 256'(nrx), 256'(nexp));
    endtask

    // monitor on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend)
                chk(out_valid && ({out_trunc, out_fixed, out_name_len, out_name} == held),
                    "R8 output held", 256'({out_trunc, out_fixed, out_name_len, out_name}), 256'(held));
            hold_pend = out_valid && !out_ready;
            held = {out_trunc, out_fixed, out_name_len, out_name};
            if (out_valid && out_ready) begin
                if (nrx < nexp) begin
                    chk(out_name == e_name[nrx], "R2/R4/R6 text bytes", 256'(out_name), 256'(e_name[nrx]));
                    chk(out_name_len == e_len[nrx],
                        (e_len[nrx] == 0) ? "R10 empty text length" : "R2 text length",
                        256'(out_name_len), 256'(e_len[nrx]));
                    chk(out_fixed == e_fix[nrx], "R3/R9 binary bytes", 256'(out_fixed), 256'(e_fix[nrx]));
                    chk(out_trunc == e_trunc[nrx], "R5 truncation flag", 256'(out_trunc), 256'(e_trunc[nrx]));
                end else begin
                    chk(1'b0, "R6 unexpected record", 256'(nrx), 256'(nexp));
                end
                nrx++;
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        nbytes = 0; pos = 0; nexp = 0; nrx = 0; hold_pend = 1'b0; saw_stall = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R1 out_valid after reset", 256'(out_valid), 256'(0));
        chk(in_ready, "R1 in_ready after reset", 256'(in_ready), 256'(1));
        chk(!err_overflow, "R1 err_overflow after reset", 256'(err_overflow), 256'(0));
    endtask

    initial begin
        do_reset();

        // table walk: varied lengths give every lane offset (R4), empty text (R10)
        for (int k = 0; k < 8; k++) add_rec(TAB[k][0], TAB[k][1]);
        pad_stream(20);
        run_stream(0);
        chk(!err_overflow, "R5 no error without overflow", 256'(err_overflow), 256'(0));

        // forced close of an over-long text field
        add_ovf(9);
        add_rec(4, 10);
        pad_stream(11);
        run_stream(0);
        chk(err_overflow, "R5 err_overflow set", 256'(err_overflow), 256'(1));
        repeat (10) @(posedge clk);
        #1;
        chk(err_overflow, "R5 err_overflow sticky", 256'(err_overflow), 256'(1));

        // reset clears the sticky flag; start again from slot 0 (R1)
        do_reset();

        // long output stall: slots and FIFO fill, input must stall (R7)
        for (int k = 0; k < 12; k++) add_rec((k * 5) % 14, 30 + k);
        pad_stream(50);
        run_stream(80);
        chk(saw_stall, "R7 in_ready dropped under stall", 256'(saw_stall), 256'(1));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule